// File: doc/BRIEF.md
# Multiframe Clock Counter with SYSREF Alignment

This block keeps the multiframe timing of a deterministic-latency serial converter link transmitter. It runs on the character clock, where each cycle carries four octets per lane, and counts cycles through one multiframe. A multiframe holds K frames of F octets, so its length is F*K/4 cycles. The block raises a one-cycle multiframe strobe on the first cycle of every multiframe. It also gives a per-octet frame-start mask, which marks the octet slots of the current cycle where a frame begins.

A SYSREF input passes through a synchronizer and a rising-edge detector. A detected edge restarts the counter, so the cycle in which the edge is detected becomes position 0 of a multiframe. SYSREF is normally periodic, with a period of two multiframes. When it stays in step with the counter, each restart lands where the counter already was, and the cadence does not change. The first edge after reset sets the phase. Any later edge that is detected off position 0 sets a sticky misalignment flag, which a clear input resets. A one-shot mode lets only the first edge move the counter; later edges are still checked for alignment.

Top module: `mfclk_aligner`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the counter is at position 0: `mf_pulse` is 1 and `misalign` is 0.
- R2: The multiframe length is M = F*K/4 cycles. F = 2^`frame_sel`, and the code 3 is treated as F=4. K = 16 when `kmf_sel`=0 and K = 32 when `kmf_sel`=1. With no SYSREF activity, `mf_pulse` is high for exactly one cycle in every M cycles.
- R3: Bit i of `frame_mark` is octet slot i of the cycle, with bit 0 the earliest. The bit is 1 exactly when i mod F = 0, which gives 4'b1111 for F=1, 4'b0101 for F=2 and 4'b0001 for F=4.
- R4: Let `sysref_in` rise so that it is first sampled high at clock edge n. The edge is then detected in the cycle after edge n+1. That cycle becomes position 0: if SYSREF stays quiet, `mf_pulse` is next high M cycles later and every M cycles after that.
- R5: Only a low-to-high transition of the synchronized SYSREF counts as an edge. Holding `sysref_in` high causes no further restarts.
- R6: An edge detected after the first edge since reset, in a cycle where `mf_pulse` is low, sets `misalign` in the next cycle. The flag then stays set. The first edge after reset never sets it.
- R7: When `err_clr` is high in a cycle, `misalign` is 0 in the next cycle, unless a misaligned edge is detected in that same cycle. In that case the flag is set.
- R8: A SYSREF edge detected in a cycle where `mf_pulse` is high leaves the multiframe cadence unchanged and does not set `misalign`.
- R9: With `oneshot_en`=1, edges after the first alignment do not move the counter, but they are still checked as in R6.
- R10: With `oneshot_en`=1, the first edge after reset still restarts the counter as in R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sysref_in | input | 1 | Asynchronous SYSREF input |
| frame_sel | input | 2 | Frame size select: F = 2^frame_sel; code 3 means F=4 |
| kmf_sel | input | 1 | Frames per multiframe: 0 gives K=16, 1 gives K=32 |
| oneshot_en | input | 1 | When 1, only the first SYSREF edge realigns the counter |
| err_clr | input | 1 | Clears the misalignment flag |
| mf_pulse | output | 1 | High in the first cycle of each multiframe |
| frame_mark | output | 4 | Octet slots of this cycle where a frame starts |
| misalign | output | 1 | Sticky flag: a SYSREF edge was seen off the multiframe boundary |

## Verification
The bench builds the block with its default parameters: four octets per cycle, K of 16 or 32, F up to 4, and a two-stage synchronizer. Walking all eight combinations of `frame_sel` and `kmf_sel` covers multiframe lengths from 4 to 32 cycles, and includes the clamped select code 3. The SYSREF tests run at F=2, K=16 (M=8). At that size, aligned edges two multiframes apart, off-boundary edges, a level held high, a clear that coincides with a set, and one-shot mode can each be placed at an exact cycle offset and checked within a few dozen cycles.

// File: rtl/mfclk_pkg.sv
package mfclk_pkg;

  // Multiframe length in character-clock cycles for a given select pair
  function automatic int unsigned mf_len(
    input int unsigned fsel,
    input int unsigned ksel,
    input int unsigned flog_max,
    input int unsigned k_short,
    input int unsigned k_long,
    input int unsigned oct_per_clk
  );
    int unsigned flog;
    int unsigned kval;
    flog = (fsel > flog_max) ? flog_max : fsel;
    kval = (ksel != 0) ? k_long : k_short;
    return ((32'd1 << flog) * kval) / oct_per_clk;
  endfunction

endpackage

// File: rtl/mfclk_sync.sv
module mfclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain[0] <= async_in;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
      last <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~last;

  // R5
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/mfclk_counter.sv
module mfclk_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W:0]   mlen,
  input  logic             edge_det,
  input  logic             oneshot_en,
  output logic [CNT_W-1:0] cnt,
  output logic             locked
);
  localparam int MLEN_W = CNT_W + 1;

  logic take;
  logic at_end;

  assign take   = edge_det && !(oneshot_en && locked);
  assign at_end = ({1'b0, cnt} >= (mlen - MLEN_W'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      locked <= 1'b0;
    end else if (take) begin
      // detection cycle is position 0, so the next cycle is position 1
      cnt    <= CNT_W'(1);
      locked <= 1'b1;
    end else if (at_end) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  // R4
  realign_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (cnt == CNT_W'(1)));

  // R2
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_det && ({1'b0, cnt} == mlen - MLEN_W'(1)) && $stable(mlen)) |=> (cnt == '0));

  // R10
  lock_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_det && !locked) |=> (locked && cnt == CNT_W'(1)));

endmodule

// File: rtl/mfclk_monitor.sv
module mfclk_monitor (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_det,
  input  logic locked,
  input  logic at_zero,
  input  logic clr,
  output logic misalign
);
  logic bad_edge;

  assign bad_edge = edge_det && locked && !at_zero;

  always_ff @(posedge clk) begin
    if (!rst_n)        misalign <= 1'b0;
    else if (bad_edge) misalign <= 1'b1;
    else if (clr)      misalign <= 1'b0;
  end

  // R6
  misalign_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_edge |=> misalign);

  // R6
  misalign_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (misalign && !clr) |=> misalign);

  // R7
  misalign_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !bad_edge) |=> !misalign);

endmodule

// File: rtl/mfclk_framemark.sv
module mfclk_framemark #(
  parameter int OCT_PER_CLK = 4,
  parameter int FSEL_W      = 2,
  parameter int F_LOG_MAX   = 2
) (
  input  logic [FSEL_W-1:0]      fsel,
  output logic [OCT_PER_CLK-1:0] mark
);
  int unsigned flog;

  always_comb begin
    flog = (32'(fsel) > 32'(F_LOG_MAX)) ? 32'(F_LOG_MAX) : 32'(fsel);
  end

  for (genvar i = 0; i < OCT_PER_CLK; i++) begin : g_lane
    localparam int unsigned LANE = i;
    assign mark[i] = ((LANE % (32'd1 << flog)) == 32'd0);
  end

endmodule

// File: rtl/mfclk_aligner.sv
module mfclk_aligner #(
  parameter int OCT_PER_CLK = 4,
  parameter int K_SHORT     = 16,
  parameter int K_LONG      = 32,
  parameter int F_LOG_MAX   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sysref_in,
  input  logic [1:0]             frame_sel,
  input  logic                   kmf_sel,
  input  logic                   oneshot_en,
  input  logic                   err_clr,
  output logic                   mf_pulse,
  output logic [OCT_PER_CLK-1:0] frame_mark,
  output logic                   misalign
);
  localparam int MAX_M  = ((1 << F_LOG_MAX) * K_LONG) / OCT_PER_CLK;
  localparam int CNT_W  = (MAX_M > 2) ? $clog2(MAX_M) : 1;
  localparam int MLEN_W = CNT_W + 1;

  logic              edge_det;
  logic [CNT_W-1:0]  cnt;
  logic              locked;
  logic [MLEN_W-1:0] mlen;

  assign mlen = MLEN_W'(mfclk_pkg::mf_len(32'(frame_sel), 32'(kmf_sel),
                                          F_LOG_MAX, K_SHORT, K_LONG, OCT_PER_CLK));

  mfclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (sysref_in),
    .rise     (edge_det)
  );

  mfclk_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .mlen       (mlen),
    .edge_det   (edge_det),
    .oneshot_en (oneshot_en),
    .cnt        (cnt),
    .locked     (locked)
  );

  assign mf_pulse = (cnt == '0);

  mfclk_monitor u_mon (
    .clk      (clk),
    .rst_n    (rst_n),
    .edge_det (edge_det),
    .locked   (locked),
    .at_zero  (mf_pulse),
    .clr      (err_clr),
    .misalign (misalign)
  );

  mfclk_framemark #(
    .OCT_PER_CLK (OCT_PER_CLK),
    .FSEL_W      (2),
    .F_LOG_MAX   (F_LOG_MAX)
  ) u_fm (
    .fsel (frame_sel),
    .mark (frame_mark)
  );

  // R8
  aligned_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_det && mf_pulse && !err_clr && !misalign) |=> !misalign);

endmodule

// File: tb/mfclk_aligner_bench.sv
module mfclk_aligner_bench;
  localparam int CLK_PERIOD = 10;
  localparam int M_DIR = 8;  // F=2, K=16

  typedef struct packed {
    logic [1:0] fs;
    logic       ks;
    logic [7:0] m;
    logic [3:0] mark;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd0, 1'b0, 8'd4,  4'hF},
    '{2'd1, 1'b0, 8'd8,  4'h5},
    '{2'd2, 1'b0, 8'd16, 4'h1},
    '{2'd3, 1'b0, 8'd16, 4'h1},
    '{2'd0, 1'b1, 8'd8,  4'hF},
    '{2'd1, 1'b1, 8'd16, 4'h5},
    '{2'd2, 1'b1, 8'd32, 4'h1},
    '{2'd3, 1'b1, 8'd32, 4'h1}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sysref = 1'b0;
  logic [1:0] fsel = 2'd0;
  logic       ksel = 1'b0;
  logic       oneshot = 1'b0;
  logic       clr = 1'b0;
  logic       mf;
  logic [3:0] mark;
  logic       mis;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mfclk_aligner u_mfclk_aligner (
    .clk        (clk),
    .rst_n      (rst_n),
    .sysref_in  (sysref),
    .frame_sel  (fsel),
    .kmf_sel    (ksel),
    .oneshot_en (oneshot),
    .err_clr    (clr),
    .mf_pulse   (mf),
    .frame_mark (mark),
    .misalign   (mis)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic to_pulse(output int n);
    n = 0;
    do begin
      tick();
      n++;
    end while (!mf && n < 200);
  endtask

  task automatic do_reset(input logic [1:0] fs, input logic ks, input logic os);
    tick();
    rst_n = 1'b0; sysref = 1'b0; clr = 1'b0;
    fsel = fs; ksel = ks; oneshot = os;
    tick(); tick(); tick();
    rst_n = 1'b1;
  endtask

  initial begin
    int n;
    // table walk: R1, R2, R3
    foreach (VECS[i]) begin
      do_reset(VECS[i].fs, VECS[i].ks, 1'b0);
      chk("R1 mf_pulse after reset", int'(mf), 1);
      chk("R1 misalign after reset", int'(mis), 0);
      chk("R3 frame_mark", int'(mark), int'(VECS[i].mark));
      to_pulse(n);
      chk("R2 multiframe period", n, int'(VECS[i].m));
      to_pulse(n);
      chk("R2 multiframe period repeat", n, int'(VECS[i].m));
    end

    // R4: first realignment, counter at position 2 when SYSREF rises
    do_reset(2'd1, 1'b0, 1'b0);
    tick(); tick();
    sysref = 1'b1;
    to_pulse(n);
    chk("R4 realign latency", n, M_DIR + 2);
    chk("R6 first edge leaves flag low", int'(mis), 0);
    // R5: level held high does not retrigger
    to_pulse(n);
    chk("R5 held level keeps cadence", n, M_DIR);
    sysref = 1'b0;

    // R8: edge detected on a pulse cycle, two multiframes later
    repeat (2*M_DIR - 2) tick();
    sysref = 1'b1;
    tick(); tick();
    chk("R8 pulse on aligned edge cycle", int'(mf), 1);
    tick();
    sysref = 1'b0;
    chk("R8 aligned edge no flag", int'(mis), 0);
    to_pulse(n);
    chk("R8 cadence unchanged", n, M_DIR - 1);

    // R6: off-boundary edge
    tick();
    sysref = 1'b1;
    tick(); tick(); tick();
    chk("R6 misalign set", int'(mis), 1);
    sysref = 1'b0;
    to_pulse(n);
    chk("R4 realigned to off-boundary edge", n, M_DIR - 1);
    repeat (3) tick();
    chk("R6 misalign sticky", int'(mis), 1);

    // R7: clear
    clr = 1'b1;
    tick();
    clr = 1'b0;
    chk("R7 clear drops flag", int'(mis), 0);

    // R7: clear coinciding with a misaligned edge
    to_pulse(n);
    tick();
    sysref = 1'b1;
    tick(); tick();
    clr = 1'b1;
    tick();
    clr = 1'b0;
    sysref = 1'b0;
    chk("R7 set wins over clear", int'(mis), 1);
    clr = 1'b1;
    tick();
    clr = 1'b0;
    chk("R7 clear after set", int'(mis), 0);

    // R10, R9: one-shot mode
    do_reset(2'd1, 1'b0, 1'b1);
    tick(); tick();
    sysref = 1'b1;
    to_pulse(n);
    chk("R10 one-shot first alignment", n, M_DIR + 2);
    sysref = 1'b0;
    tick();
    sysref = 1'b1;
    to_pulse(n);
    sysref = 1'b0;
    chk("R9 later edge ignored", n, M_DIR - 1);
    chk("R9 later edge still checked", int'(mis), 1);
    to_pulse(n);
    chk("R9 cadence kept", n, M_DIR);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule